// File: doc/BRIEF.md
# Four-Bank Busy and Status Tracker

This block sits beside a four-bank flash array and keeps track of which bank is running an embedded program or erase. A new read address is steered in the same cycle, with no register on the path. A read that lands in the busy bank gets a polling status word. A read anywhere else gets array data. The block also drives the value of status bit 7, so the host can poll for completion.

An erase can be suspended. While it is suspended, the other sectors of the erasing bank read as array data, and a single program may run in any sector except the one being erased. A resume command puts the erase back into its busy state. When the algorithm engine reports completion, the bank that was working goes back to array reads by itself.

Top module: `bank_busy_tracker`

## Requirements
- R1: After reset no bank is busy, `erase_suspended` is 0, `busy_bank` is 0, and every read address gives `rd_status_sel` = 0 (array data).
- R2: Suppose `op_start` is sampled high while idle. In the following cycle `start_ack` is 1 for one cycle, `op_busy` is 1, and `busy_bank` equals bits [22:21] of `op_addr`. `op_kind` 0 means program and 1 means erase.
- R3: A read whose bank (bits [22:21] of `rd_addr`) differs from the busy bank gives `rd_status_sel` = 0, combinationally and in the same cycle.
- R4: During a program, a read in the busy bank gives `rd_status_sel` = 1 and `rd_dq7` = the complement of the `op_dq7` value captured at start.
- R5: During an active erase, a read in the busy bank gives `rd_status_sel` = 1 and `rd_dq7` = 0.
- R6: A cycle with `op_done` high ends a running program or erase. In the next cycle `op_busy` is 0 and that bank reads array data. `op_done` takes priority over a suspend command in the same cycle.
- R7: While a program or an unsuspended erase is running, `op_start` is rejected: no `start_ack`, and `busy_bank` is unchanged.
- R8: `suspend_cmd` during an active erase sets `erase_suspended` in the next cycle. While suspended, the erased sector (bits [22:15]) reads status with `rd_dq7` = 1, and the other sectors of that bank read array data.
- R9: `resume_cmd` while suspended with no program running clears `erase_suspended` and brings back erase status (`rd_dq7` = 0) across the whole bank.
- R10: While suspended, a program start to any sector other than the erased one is acknowledged. `busy_bank` shows the program's bank, and reads in that bank give `rd_dq7` = complement of its bit. Its `op_done` returns to the suspended erase, with `busy_bank` = the erase bank.
- R11: While suspended, a program to the erased sector is rejected, and so is any erase start.
- R12: Suspend or resume commands given outside their valid state have no effect. Valid states: suspend during an active erase; resume while suspended with no program running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | Request to start an embedded operation |
| op_kind | input | 1 | 0 program, 1 erase |
| op_addr | input | 23 | Target word address of the operation |
| op_dq7 | input | 1 | Bit 7 of the data being programmed |
| op_done | input | 1 | Completion pulse from the algorithm engine |
| suspend_cmd | input | 1 | Erase suspend command |
| resume_cmd | input | 1 | Erase resume command |
| rd_addr | input | 23 | Current read word address |
| op_busy | output | 1 | An operation is in progress (including suspended erase) |
| busy_bank | output | 2 | Bank of the operation now in progress |
| erase_suspended | output | 1 | An erase is suspended |
| start_ack | output | 1 | One-cycle acknowledge of an accepted start |
| rd_status_sel | output | 1 | 1 selects status data, 0 selects array data |
| rd_dq7 | output | 1 | Status bit 7 value (0 when array selected) |

## Verification
The bench sweeps every pairing of busy bank and read bank, for programs with both data bit values and for erases. A decoder that compared the wrong address bits, or that added a register on the read path, would show status in the wrong bank or a cycle late. The suspend sequence checks the following:
- the erased sector against its neighbours;
- a program into a different bank and into the same bank;
- rejection of a program aimed at the erased sector;
- a resume issued while the suspended program is still running.

A design that lost the erase context across the nested program would resume into the wrong bank or report the wrong bit 7. The priority of `op_done` over a suspend in the same cycle is also checked, along with stray suspend and resume commands in idle and during a program.

// File: rtl/bbt_pkg.sv
package bbt_pkg;
    typedef enum logic [2:0] {
        M_IDLE  = 3'd0,
        M_PROG  = 3'd1,
        M_ERASE = 3'd2,
        M_ESUSP = 3'd3,
        M_SPROG = 3'd4
    } mode_e;

    localparam logic KIND_PROG  = 1'b0;
    localparam logic KIND_ERASE = 1'b1;
endpackage

// File: rtl/bbt_addr_split.sv
module bbt_addr_split #(
    parameter int ADDR_W   = 23,
    parameter int BANK_W   = 2,
    parameter int SECT_LSB = 15,
    localparam int SECT_W  = ADDR_W - SECT_LSB
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank,
    output logic [SECT_W-1:0] sect
);
    // bank is the top slice; sector id spans bank bits too, so it is unique chip-wide
    assign bank = addr[ADDR_W-1 -: BANK_W];
    assign sect = addr[ADDR_W-1 : SECT_LSB];
endmodule

// File: rtl/bbt_op_ctrl.sv
module bbt_op_ctrl
    import bbt_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int SECT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              kind,
    input  logic [BANK_W-1:0] st_bank,
    input  logic [SECT_W-1:0] st_sect,
    input  logic              st_bit7,
    input  logic              done,
    input  logic              susp,
    input  logic              resume,
    output mode_e             mode,
    output logic [BANK_W-1:0] main_bank,
    output logic [SECT_W-1:0] main_sect,
    output logic              main_exp7,
    output logic [BANK_W-1:0] nest_bank,
    output logic              nest_exp7,
    output logic              ack
);
    typedef struct packed {
        mode_e             mode;
        logic [BANK_W-1:0] bank;
        logic [SECT_W-1:0] sect;
        logic              exp7;
        logic [BANK_W-1:0] nbank;
        logic              nexp7;
        logic              ack;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;
        unique case (st_q.mode)
            M_IDLE: begin
                if (start) begin
                    st_d.mode = (kind == KIND_ERASE) ? M_ERASE : M_PROG;
                    st_d.bank = st_bank;
                    st_d.sect = st_sect;
                    st_d.exp7 = st_bit7;
                    st_d.ack  = 1'b1;
                end
            end
            M_PROG: begin
                if (done) st_d.mode = M_IDLE;
            end
            M_ERASE: begin
                if (done)      st_d.mode = M_IDLE;
                else if (susp) st_d.mode = M_ESUSP;
            end
            M_ESUSP: begin
                if (resume) begin
                    st_d.mode = M_ERASE;
                end else if (start && kind == KIND_PROG && st_sect != st_q.sect) begin
                    st_d.mode  = M_SPROG;
                    st_d.nbank = st_bank;
                    st_d.nexp7 = st_bit7;
                    st_d.ack   = 1'b1;
                end
            end
            M_SPROG: begin
                if (done) st_d.mode = M_ESUSP;
            end
            default: st_d.mode = M_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: M_IDLE, bank: '0, sect: '0, exp7: 1'b0,
                      nbank: '0, nexp7: 1'b0, ack: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode      = st_q.mode;
    assign main_bank = st_q.bank;
    assign main_sect = st_q.sect;
    assign main_exp7 = st_q.exp7;
    assign nest_bank = st_q.nbank;
    assign nest_exp7 = st_q.nexp7;
    assign ack       = st_q.ack;

    a_r6_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mode == M_PROG || st_q.mode == M_ERASE) && done) |=> (st_q.mode == M_IDLE));

    a_r7_no_ack_running: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_PROG || st_q.mode == M_ERASE || st_q.mode == M_SPROG) |=> !st_q.ack);

    a_r8_susp_from_erase: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_ESUSP && $past(st_q.mode) != M_ESUSP)
            |-> ($past(st_q.mode) == M_ERASE || $past(st_q.mode) == M_SPROG));

    a_r10_nested_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_SPROG && done) |=> (st_q.mode == M_ESUSP && $stable(st_q.bank)));
endmodule

// File: rtl/bbt_read_steer.sv
module bbt_read_steer
    import bbt_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int SECT_W = 8
) (
    input  mode_e             mode,
    input  logic [BANK_W-1:0] main_bank,
    input  logic [SECT_W-1:0] main_sect,
    input  logic              main_exp7,
    input  logic [BANK_W-1:0] nest_bank,
    input  logic              nest_exp7,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [SECT_W-1:0] rd_sect,
    output logic              sel_status,
    output logic              dq7
);
    logic hit_main, hit_sect, hit_nest;

    always_comb begin
        hit_main   = (rd_bank == main_bank);
        hit_sect   = (rd_sect == main_sect);
        hit_nest   = (rd_bank == nest_bank);
        sel_status = 1'b0;
        dq7        = 1'b0;
        unique case (mode)
            M_PROG: begin
                if (hit_main) begin
                    sel_status = 1'b1;
                    dq7        = ~main_exp7;
                end
            end
            M_ERASE: begin
                if (hit_main) sel_status = 1'b1;
            end
            M_ESUSP: begin
                if (hit_sect) begin
                    sel_status = 1'b1;
                    dq7        = 1'b1;
                end
            end
            M_SPROG: begin
                if (hit_nest) begin
                    sel_status = 1'b1;
                    dq7        = ~nest_exp7;
                end else if (hit_sect) begin
                    sel_status = 1'b1;
                    dq7        = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bank_busy_tracker.sv
module bank_busy_tracker
    import bbt_pkg::*;
#(
    parameter int ADDR_W   = 23,
    parameter int BANK_W   = 2,
    parameter int SECT_LSB = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic              op_kind,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic              op_dq7,
    input  logic              op_done,
    input  logic              suspend_cmd,
    input  logic              resume_cmd,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              op_busy,
    output logic [BANK_W-1:0] busy_bank,
    output logic              erase_suspended,
    output logic              start_ack,
    output logic              rd_status_sel,
    output logic              rd_dq7
);
    localparam int SECT_W = ADDR_W - SECT_LSB;
    localparam int N_PORT = 2;  // 0: operation address, 1: read address

    logic [N_PORT-1:0][ADDR_W-1:0] addr_in;
    logic [N_PORT-1:0][BANK_W-1:0] bank_of;
    logic [N_PORT-1:0][SECT_W-1:0] sect_of;

    assign addr_in[0] = op_addr;
    assign addr_in[1] = rd_addr;

    for (genvar g = 0; g < N_PORT; g++) begin : g_split
        bbt_addr_split #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .SECT_LSB(SECT_LSB)) u_split (
            .addr (addr_in[g]),
            .bank (bank_of[g]),
            .sect (sect_of[g])
        );
    end

    mode_e             mode;
    logic [BANK_W-1:0] main_bank, nest_bank;
    logic [SECT_W-1:0] main_sect;
    logic              main_exp7, nest_exp7;

    bbt_op_ctrl #(.BANK_W(BANK_W), .SECT_W(SECT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (op_start),
        .kind      (op_kind),
        .st_bank   (bank_of[0]),
        .st_sect   (sect_of[0]),
        .st_bit7   (op_dq7),
        .done      (op_done),
        .susp      (suspend_cmd),
        .resume    (resume_cmd),
        .mode      (mode),
        .main_bank (main_bank),
        .main_sect (main_sect),
        .main_exp7 (main_exp7),
        .nest_bank (nest_bank),
        .nest_exp7 (nest_exp7),
        .ack       (start_ack)
    );

    bbt_read_steer #(.BANK_W(BANK_W), .SECT_W(SECT_W)) u_steer (
        .mode       (mode),
        .main_bank  (main_bank),
        .main_sect  (main_sect),
        .main_exp7  (main_exp7),
        .nest_bank  (nest_bank),
        .nest_exp7  (nest_exp7),
        .rd_bank    (bank_of[1]),
        .rd_sect    (sect_of[1]),
        .sel_status (rd_status_sel),
        .dq7        (rd_dq7)
    );

    always_comb begin
        op_busy         = (mode != M_IDLE);
        erase_suspended = (mode == M_ESUSP) || (mode == M_SPROG);
        unique case (mode)
            M_IDLE:  busy_bank = '0;
            M_SPROG: busy_bank = nest_bank;
            default: busy_bank = main_bank;
        endcase
    end

    a_r1_idle_reads_array: assert property (@(posedge clk) disable iff (!rst_n)
        !op_busy |-> !rd_status_sel);

    a_r3_other_bank_array: assert property (@(posedge clk) disable iff (!rst_n)
        (op_busy && !erase_suspended && rd_addr[ADDR_W-1 -: BANK_W] != busy_bank)
            |-> !rd_status_sel);

    a_r2_ack_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_ack |-> ($past(op_start) && op_busy));
endmodule

// File: tb/bank_busy_tracker_bench.sv
module bank_busy_tracker_bench;
    localparam int AW = 23;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_start = 1'b0, op_kind = 1'b0, op_dq7 = 1'b0, op_done = 1'b0;
    logic suspend_cmd = 1'b0, resume_cmd = 1'b0;
    logic [AW-1:0] op_addr = '0, rd_addr = '0;
    logic op_busy, erase_suspended, start_ack, rd_status_sel, rd_dq7;
    logic [1:0] busy_bank;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bank_busy_tracker u_bank_busy_tracker (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
        .op_addr(op_addr), .op_dq7(op_dq7), .op_done(op_done),
        .suspend_cmd(suspend_cmd), .resume_cmd(resume_cmd), .rd_addr(rd_addr),
        .op_busy(op_busy), .busy_bank(busy_bank), .erase_suspended(erase_suspended),
        .start_ack(start_ack), .rd_status_sel(rd_status_sel), .rd_dq7(rd_dq7)
    );

    function automatic logic [AW-1:0] mk(int b, int s, int o);
        return AW'((b << 21) | (s << 15) | o);
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // read check: set address away from the edge, settle, compare
    task automatic rd(string tag, logic [AW-1:0] a, int esel, int edq);
        rd_addr = a;
        #1;
        chk({tag, " sel"}, int'(rd_status_sel), esel);
        chk({tag, " dq7"}, int'(rd_dq7), edq);
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic start(int kind, logic [AW-1:0] a, int bit7);
        op_start = 1'b1; op_kind = kind[0]; op_addr = a; op_dq7 = bit7[0];
        cyc();
        op_start = 1'b0;
    endtask

    task automatic done();
        op_done = 1'b1; cyc(); op_done = 1'b0;
    endtask

    task automatic susp();
        suspend_cmd = 1'b1; cyc(); suspend_cmd = 1'b0;
    endtask

    task automatic resm();
        resume_cmd = 1'b1; cyc(); resume_cmd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        chk("R1 busy", int'(op_busy), 0);
        chk("R1 susp", int'(erase_suspended), 0);
        chk("R1 bank", int'(busy_bank), 0);
        for (int b = 0; b < 4; b++) rd("R1 read", mk(b, 3, 9), 0, 0);

        // R12 stray commands in idle
        susp(); resm();
        chk("R12 idle busy", int'(op_busy), 0);
        chk("R12 idle susp", int'(erase_suspended), 0);

        // sweep: kind x busy bank x bit x read bank
        for (int k = 0; k < 2; k++) begin
            for (int b = 0; b < 4; b++) begin
                for (int v = 0; v < 2; v++) begin
                    start(k, mk(b, 5, 7), v);
                    chk("R2 ack", int'(start_ack), 1);
                    chk("R2 busy", int'(op_busy), 1);
                    chk("R2 bank", int'(busy_bank), b);
                    cyc();
                    chk("R2 ack pulse", int'(start_ack), 0);
                    for (int r = 0; r < 4; r++) begin
                        if (r != b) rd("R3 other bank", mk(r, 5, 1), 0, 0);
                        else if (k == 0) rd("R4 prog status", mk(r, 5, 1), 1, 1 - v);
                        else rd("R5 erase status", mk(r, 5, 1), 1, 0);
                    end
                    // R7 reject start in another bank
                    start(0, mk((b + 1) % 4, 2, 0), 0);
                    chk("R7 no ack", int'(start_ack), 0);
                    chk("R7 bank kept", int'(busy_bank), b);
                    if (k == 0) begin
                        susp();
                        chk("R12 susp in prog", int'(erase_suspended), 0);
                        rd("R12 prog still status", mk(b, 0, 0), 1, 1 - v);
                    end
                    done();
                    chk("R6 idle", int'(op_busy), 0);
                    rd("R6 array", mk(b, 5, 7), 0, 0);
                end
            end
        end

        // R6 done wins over suspend in the same cycle
        start(1, mk(3, 1, 0), 0);
        op_done = 1'b1; suspend_cmd = 1'b1; cyc();
        op_done = 1'b0; suspend_cmd = 1'b0;
        chk("R6 done priority busy", int'(op_busy), 0);
        chk("R6 done priority susp", int'(erase_suspended), 0);

        // suspend sequence: erase bank 2 sector 9
        start(1, mk(2, 9, 0), 0);
        susp();
        chk("R8 suspended", int'(erase_suspended), 1);
        chk("R8 bank", int'(busy_bank), 2);
        rd("R8 erased sector", mk(2, 9, 100), 1, 1);
        rd("R8 other sector", mk(2, 3, 100), 0, 0);
        rd("R8 other bank", mk(0, 9, 100), 0, 0);
        susp();
        chk("R12 double susp", int'(erase_suspended), 1);

        start(0, mk(2, 9, 4), 1);
        chk("R11 same sector no ack", int'(start_ack), 0);
        chk("R11 bank kept", int'(busy_bank), 2);
        start(1, mk(1, 0, 0), 0);
        chk("R11 erase no ack", int'(start_ack), 0);
        rd("R11 still array", mk(1, 0, 0), 0, 0);

        start(0, mk(1, 4, 2), 0);
        chk("R10 ack", int'(start_ack), 1);
        chk("R10 bank", int'(busy_bank), 1);
        rd("R10 prog status", mk(1, 7, 0), 1, 1);
        rd("R10 erased sector", mk(2, 9, 0), 1, 1);
        rd("R10 erase bank other", mk(2, 3, 0), 0, 0);
        resm();
        chk("R12 resume during prog", int'(erase_suspended), 1);
        chk("R12 bank kept", int'(busy_bank), 1);
        done();
        chk("R10 back susp", int'(erase_suspended), 1);
        chk("R10 back bank", int'(busy_bank), 2);
        rd("R10 bank1 array", mk(1, 7, 0), 0, 0);

        start(0, mk(2, 3, 5), 1);
        chk("R10 same bank ack", int'(start_ack), 1);
        rd("R10 same bank status", mk(2, 3, 5), 1, 0);
        done();

        resm();
        chk("R9 resumed", int'(erase_suspended), 0);
        chk("R9 busy", int'(op_busy), 1);
        rd("R9 bank status", mk(2, 3, 0), 1, 0);
        rd("R9 sector status", mk(2, 9, 0), 1, 0);
        done();
        chk("R6 final idle", int'(op_busy), 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule